// File: doc/BRIEF.md
# Binary Strip Hit Readout Buffer

This block holds one-bit comparator hits from a silicon strip front end until a trigger decides whether they are read out. On every bunch crossing (one clock cycle) it writes a 254-bit hit word into a 256-entry circular latency pipeline. When a trigger strobe arrives, the word written a programmed number of crossings earlier is copied, together with its pipeline address, into a 32-event derandomizing buffer.

A serializer drains the buffer one event at a time. It sends an unsparsified frame on a single output bit, most significant bit first. Each frame has 265 bits: an 11-bit header, then all 254 hit bits, with the two sensor layers interleaved. A fast-reset strobe returns the pipeline write address, the buffer and the serializer to their starting state.

The serializer is a two-state machine. SER_IDLE holds the output at 0. SER_SEND shifts out one frame bit per crossing. There are three transitions:
- SER_IDLE to SER_SEND when the buffer holds an event.
- SER_SEND to SER_SEND, reloading the shift register, after the last bit of a frame when another event is waiting.
- SER_SEND to SER_IDLE after the last bit when the buffer is empty.

Fast reset forces SER_IDLE from either state.

Top module: `strip_hit_readout`

## Requirements
- R1: A trigger sampled at a clock edge, where the pipeline write address is w, captures the hit word that was written at address w-L (modulo 256), which is the word written L crossings earlier. L is the latency input, with a legal range of 1 to 255.
- R2: A frame is 265 bits, sent most significant bit first. Its header is, in order: two start bits equal to 1, one error bit, and the 8-bit pipeline address of the captured word (MSB first).
- R3: After the header the frame carries, for k = 0 to 126, hits[k] (upper layer channel k) followed by hits[127+k] (lower layer channel k).
- R4: With the serializer idle and the buffer empty, the first start bit appears on the output in the cycle that follows the first clock edge after the trigger edge.
- R5: The buffer holds up to 32 events. A trigger arriving while all 32 slots are full is dropped and sets a sticky error flag. The flag is sent as the header error bit of every frame loaded while it is set.
- R6: Fast reset takes effect at the clock edge where it is sampled, and does four things:
  - The output reads 0 from the next cycle.
  - Buffered events and the frame in flight are discarded.
  - The write address restarts at 0 at the following edge.
  - The error flag clears.
- R7: The output is 0 after reset and whenever no frame is being sent.
- R8: Frames leave in trigger order. When an event is waiting, the next frame starts in the cycle right after the previous frame's last bit, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_rst | input | 1 | Synchronous fast reset strobe |
| trig | input | 1 | Trigger strobe, one event per high cycle |
| hits | input | 254 | Comparator hits; [126:0] upper layer, [253:127] lower layer |
| latency | input | 8 | Trigger latency in crossings (1 to 255) |
| dout | output | 1 | Serial frame output |

## Verification
A trigger sampled at edge n loads the serializer at edge n+1. Frame bit i is therefore valid from edge n+1+i until the next edge, and each following frame starts exactly 265 edges after the previous one. The bench drives inputs and samples the output on falling edges. It records the index n of the edge each trigger falls on, then reads exactly 265 falling-edge samples per frame, starting one falling edge after the trigger edge. Expected frames are built from a hit pattern that the bench computes from the crossing index, so the captured word and the address follow from n-L. Idle and fast-reset effects are checked on the first falling edge after the edge they concern.

// File: rtl/strip_rd_pkg.sv
package strip_rd_pkg;
    localparam int CHANNELS   = 254;
    localparam int PIPE_AW    = 8;
    localparam int EVT_AW     = 5;
    localparam logic [1:0] START_BITS = 2'b11;

    typedef enum logic {
        SER_IDLE = 1'b0,
        SER_SEND = 1'b1
    } ser_state_e;
endpackage

// File: rtl/strip_lat_pipe.sv
module strip_lat_pipe #(
    parameter int NCH = 254,
    parameter int AW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fast_rst,
    input  logic           trig,
    input  logic [NCH-1:0] hits,
    input  logic [AW-1:0]  latency,
    output logic [NCH-1:0] cap_word,
    output logic [AW-1:0]  cap_addr
);
    localparam int DEPTH = 2 ** AW;

    logic [NCH-1:0] store [DEPTH];
    logic [AW-1:0]  wr_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        wr_addr <= '0;
        else if (fast_rst) wr_addr <= '0;
        else               wr_addr <= wr_addr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst_n && !fast_rst) store[wr_addr] <= hits;
    end

    assign cap_addr = wr_addr - latency;
    assign cap_word = store[cap_addr];

    AST_LAT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> (latency != '0));  // R1
endmodule

// File: rtl/strip_evt_buf.sv
module strip_evt_buf #(
    parameter int W  = 262,
    parameter int AW = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fast_rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         ovf_err
);
    localparam int DEPTH = 2 ** AW;

    logic [W-1:0]  slots [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   fill;
    logic          full, accept, drop, take;

    assign full   = (fill == (AW+1)'(DEPTH));
    assign empty  = (fill == '0);
    assign accept = push && !full;
    assign drop   = push && full;
    assign take   = pop && !empty;
    assign dout   = slots[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            fill    <= '0;
            ovf_err <= 1'b0;
        end else if (fast_rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            fill    <= '0;
            ovf_err <= 1'b0;
        end else begin
            if (accept) wr_ptr <= wr_ptr + 1'b1;
            if (take)   rd_ptr <= rd_ptr + 1'b1;
            fill <= fill + (AW+1)'(accept) - (AW+1)'(take);
            if (drop)   ovf_err <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst_n && !fast_rst && accept) slots[wr_ptr] <= din;
    end

    AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !fast_rst) |=> ovf_err);  // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_err && !fast_rst) |=> ovf_err);  // R5
    AST_FRESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        fast_rst |=> (empty && !ovf_err));  // R6
endmodule

// File: rtl/strip_frame_ser.sv
module strip_frame_ser
    import strip_rd_pkg::*;
#(
    parameter int NCH = 254,
    parameter int AW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fast_rst,
    input  logic           evt_valid,
    input  logic [NCH-1:0] evt_hits,
    input  logic [AW-1:0]  evt_addr,
    input  logic           err_flag,
    output logic           evt_pop,
    output logic           dout
);
    localparam int HALF = NCH / 2;
    localparam int FB   = NCH + AW + 3;
    localparam int CW   = $clog2(FB);
    localparam logic [CW-1:0] LAST = CW'(FB - 1);

    ser_state_e    state, state_nx;
    logic [FB-1:0] shreg, frame;
    logic [CW-1:0] bit_cnt;
    logic          at_end;

    assign at_end  = (bit_cnt == LAST);
    assign evt_pop = evt_valid && !fast_rst &&
                     ((state == SER_IDLE) || at_end);
    assign dout    = shreg[FB-1];

    always_comb begin
        frame = '0;
        frame[FB-1 -: 2]  = START_BITS;
        frame[FB-3]       = err_flag;
        frame[FB-4 -: AW] = evt_addr;
        for (int k = 0; k < HALF; k++) begin
            frame[NCH-1-2*k] = evt_hits[k];
            frame[NCH-2-2*k] = evt_hits[HALF+k];
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SER_IDLE: if (evt_valid)  state_nx = SER_SEND;
            SER_SEND: if (at_end && !evt_valid) state_nx = SER_IDLE;
        endcase
        if (fast_rst) state_nx = SER_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SER_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (fast_rst) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (evt_pop) begin
            shreg   <= frame;
            bit_cnt <= '0;
        end else if (state == SER_SEND && at_end) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (state == SER_SEND) begin
            shreg   <= {shreg[FB-2:0], 1'b0};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SER_IDLE) |-> (dout == 1'b0));  // R7
    AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SER_SEND && at_end && evt_valid && !fast_rst)
        |=> (state == SER_SEND && bit_cnt == '0 && dout));  // R8
    AST_FRESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        fast_rst |=> (state == SER_IDLE && !dout));  // R6
endmodule

// File: rtl/strip_hit_readout.sv
module strip_hit_readout
    import strip_rd_pkg::*;
#(
    parameter int NCH     = CHANNELS,
    parameter int PIPE_W  = PIPE_AW,
    parameter int BUF_W   = EVT_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_rst,
    input  logic              trig,
    input  logic [NCH-1:0]    hits,
    input  logic [PIPE_W-1:0] latency,
    output logic              dout
);
    localparam int EW = NCH + PIPE_W;

    logic [NCH-1:0]    cap_word;
    logic [PIPE_W-1:0] cap_addr;
    logic [EW-1:0]     head_evt;
    logic              buf_empty, buf_err, pop;

    strip_lat_pipe #(.NCH(NCH), .AW(PIPE_W)) u_pipe (
        .clk(clk), .rst_n(rst_n), .fast_rst(fast_rst), .trig(trig),
        .hits(hits), .latency(latency),
        .cap_word(cap_word), .cap_addr(cap_addr)
    );

    strip_evt_buf #(.W(EW), .AW(BUF_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .fast_rst(fast_rst),
        .push(trig), .din({cap_addr, cap_word}),
        .pop(pop), .dout(head_evt), .empty(buf_empty), .ovf_err(buf_err)
    );

    strip_frame_ser #(.NCH(NCH), .AW(PIPE_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .fast_rst(fast_rst),
        .evt_valid(!buf_empty), .evt_hits(head_evt[NCH-1:0]),
        .evt_addr(head_evt[EW-1 -: PIPE_W]), .err_flag(buf_err),
        .evt_pop(pop), .dout(dout)
    );
endmodule

// File: tb/tb_strip_hit_readout.sv
module tb_strip_hit_readout;
    localparam int NCH = 254;
    localparam int FB  = 265;
    localparam int NTAB = 6;
    localparam int LAT_TAB  [NTAB] = '{1, 7, 100, 255, 2, 64};
    localparam int GAP_TAB  [NTAB] = '{260, 3, 40, 10, 0, 500};

    logic clk = 1'b0, rst_n = 1'b0, fast_rst = 1'b0, trig = 1'b0;
    logic [NCH-1:0] hits = '0;
    logic [7:0] latency = 8'd1;
    logic dout;
    int ecnt = 0, n_run = 0, n_fail = 0;
    bit done = 0;

    strip_hit_readout dut (.clk(clk), .rst_n(rst_n), .fast_rst(fast_rst),
        .trig(trig), .hits(hits), .latency(latency), .dout(dout));

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n || fast_rst) ecnt <= 0;
        else                    ecnt <= ecnt + 1;
    end

    function automatic logic [NCH-1:0] pat(int e);
        logic [NCH-1:0] v;
        for (int i = 0; i < NCH; i++)
            v[i] = (((e * 7) + (i * 3) + ((e / 5) * (i % 11))) % 5) < 2;
        return v;
    endfunction

    function automatic logic [FB-1:0] mk_frame(int e, int lat, bit err);
        logic [FB-1:0] f;
        logic [NCH-1:0] w;
        logic [7:0] a;
        w = pat(e - lat);
        a = 8'((e - lat) & 255);
        f[FB-1] = 1'b1; f[FB-2] = 1'b1; f[FB-3] = err;
        f[FB-4 -: 8] = a;
        for (int k = 0; k < 127; k++) begin
            f[NCH-1-2*k] = w[k];
            f[NCH-2-2*k] = w[127+k];
        end
        return f;
    endfunction

    initial forever begin
        @(negedge clk);
        hits = pat(ecnt);
    end

    task automatic chk(bit ok, string req, logic [FB-1:0] act, logic [FB-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // k consecutive triggers; nfr frames read back-to-back; frames from index err_from carry the error bit
    task automatic run_burst(int k, int lat, int nfr, int err_from, string req);
        int n0;
        @(negedge clk);
        latency = 8'(lat);
        n0 = ecnt;
        fork
            begin
                trig = 1'b1;
                repeat (k) @(negedge clk);
                trig = 1'b0;
            end
            begin
                @(negedge clk);
                for (int f = 0; f < nfr; f++) begin
                    logic [FB-1:0] got, exp;
                    exp = mk_frame(n0 + f, lat, f >= err_from);
                    for (int i = 0; i < FB; i++) begin
                        @(negedge clk);
                        got[FB-1-i] = dout;
                    end
                    chk(got === exp, req, got, exp);
                end
            end
        join
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(dout === 1'b0, "R7 idle after frames", FB'(dout), '0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(dout === 1'b0, "R7 reset state", FB'(dout), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dout === 1'b0, "R7 after reset release", FB'(dout), '0);

        // table of latency / spacing vectors: single triggers (R1 R2 R3 R4)
        for (int t = 0; t < NTAB; t++) begin
            repeat (GAP_TAB[t]) @(negedge clk);
            run_burst(1, LAT_TAB[t], 1, 99, "R1 R2 R3 R4 single frame");
        end

        // two triggers on adjacent crossings: contiguous frames in order (R8)
        repeat (20) @(negedge clk);
        run_burst(2, 30, 2, 99, "R8 back-to-back frames");

        // 34 adjacent triggers: 33 stored (1 sending + 32 buffered), last dropped, error bit from frame 2 (R5)
        repeat (10) @(negedge clk);
        run_burst(34, 12, 33, 1, "R5 buffer full drop and error bit");

        // fast reset mid-frame with buffered events (R6)
        @(negedge clk);
        latency = 8'd9;
        trig = 1'b1;
        repeat (3) @(negedge clk);
        trig = 1'b0;
        repeat (20) @(negedge clk);
        fast_rst = 1'b1;
        @(negedge clk);
        fast_rst = 1'b0;
        chk(dout === 1'b0, "R6 output low after fast reset", FB'(dout), '0);
        begin
            int ones = 0;
            for (int i = 0; i < 600; i++) begin
                @(negedge clk);
                if (dout) ones++;
            end
            chk(ones == 0, "R6 buffered events discarded", FB'(ones), '0);
        end
        // address restarts from 0 and error flag is clear (R6)
        run_burst(1, 9, 1, 99, "R6 address restart and error cleared");

        // latency wrap across the pipeline end (R1)
        repeat (40) @(negedge clk);
        run_burst(1, 200, 1, 99, "R1 wrapped latency");

        finish_up();
    end
endmodule